// File: doc/BRIEF.md
# Pipelined Custom-Float Adder

This block adds two numbers held in a compact floating-point format. The format keeps an IEEE-like field layout but has no NaN, no subnormals and no negative zero. A word is a sign bit, then a biased exponent of `WEXP` bits, then the significand with its leading one left out, so the word is `WEXP+WMAN` bits wide. An exponent field of zero always means zero. An exponent field of all ones means infinity, whatever the fraction bits hold.

The adder is a two-stage pipeline with no stall path and no backpressure. A pair of operands is presented with `in_valid`, and the rounded sum leaves with `out_valid` exactly two cycles later. A new pair may enter on every cycle.

The first stage canonicalises the operands, orders them by magnitude and aligns the smaller one, folding the bits it shifts out into a sticky bit. The second stage adds or subtracts, normalises, rounds to nearest with ties to even, and applies the infinity, overflow and underflow rules. The `LATENCY` parameter lets an integrator pin the stage count: zero skips the check, and any other value must equal 2 or elaboration stops.

Top module: `cfloat_add`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high. The initiation interval is one pair per cycle. After reset, `out_valid` and `out_sum` are 0.
- R2: Any operand whose exponent field is 0 counts as zero, and its sign and fraction bits are ignored. Adding a zero to a finite nonzero x returns x unchanged. A zero result is always the all-zero word.
- R3: Finite results are rounded to nearest, and a tie goes to the neighbour whose fraction LSB (bit 0) is 0.
- R4: +∞ plus −∞ gives +0. Infinity plus any finite value gives that infinity. Two infinities of the same sign give that infinity.
- R5: A rounded result whose exponent would reach or exceed the all-ones code becomes infinity, with the sign of the exact sum. This includes overflow that is caused by rounding up.
- R6: A nonzero exact result below half the minimum normal gives +0. A result at or above half the minimum normal, but below the minimum normal, gives the minimum normal (exponent field 1, fraction 0) with the sign of the result.
- R7: Operands of equal magnitude and opposite sign give +0.
- R8: An exponent field of all ones is treated as infinity whatever the fraction holds. An infinite output always carries fraction 0.
- R9: A `LATENCY` of 0 or 2 elaborates and does not change behaviour. Any other value stops elaboration.
- R10: Bits of the smaller operand that alignment shifts below the round position still take part in rounding through a sticky bit. This holds even when the exponent gap exceeds the significand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair valid this cycle |
| in_a | input | WEXP+WMAN | First operand |
| in_b | input | WEXP+WMAN | Second operand |
| out_valid | output | 1 | Sum valid this cycle |
| out_sum | output | WEXP+WMAN | Rounded sum |

## Verification
The bench aims at rounding ties, both with and without sticky bits behind them, including a subtraction whose tie carries the result back up to 1.0. An adder that dropped the sticky bit or rounded ties away from zero would be off by one ULP on these vectors. It drives sums that land in the band below the minimum normal. A flush-to-zero design would return +0 where the signed minimum normal is due, and a design with subnormals would return a small nonzero pattern. It also mixes infinities whose fraction bits are nonzero, opposite-signed infinities, and a rounding carry at the largest finite value. A design that decoded infinity from the fraction, produced a NaN-like pattern, or missed the carry into the exponent would give the wrong word.

// File: rtl/cfloat_add.sv
module cfloat_add #(
  parameter int WEXP    = 8,
  parameter int WMAN    = 24,
  parameter int LATENCY = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [WEXP+WMAN-1:0] in_a,
  input  logic [WEXP+WMAN-1:0] in_b,
  output logic                 out_valid,
  output logic [WEXP+WMAN-1:0] out_sum
);
  localparam int WF     = WMAN - 1;
  localparam int WFULL  = WEXP + WMAN;
  localparam int W      = WMAN + 3;
  localparam int STAGES = 2;
  localparam int EMAX   = (1 << WEXP) - 1;
  localparam logic [WEXP-1:0] EONES = '1;

  if (LATENCY != 0 && LATENCY != STAGES) begin : g_latency_mismatch
    $error("cfloat_add: LATENCY does not match the stage count");
  end

  wire [WEXP-1:0] ea = in_a[WFULL-2 -: WEXP];
  wire [WEXP-1:0] eb = in_b[WFULL-2 -: WEXP];
  wire za = (ea == '0);
  wire zb = (eb == '0);
  wire ia = (ea == EONES);
  wire ib = (eb == EONES);
  wire [WFULL-2:0] ka = za ? '0 : in_a[WFULL-2:0];
  wire [WFULL-2:0] kb = zb ? '0 : in_b[WFULL-2:0];
  wire sa = in_a[WFULL-1] & ~za;
  wire sb = in_b[WFULL-1] & ~zb;
  wire a_big = (ka >= kb);
  wire [WFULL-2:0] kbig = a_big ? ka : kb;
  wire [WFULL-2:0] ksm  = a_big ? kb : ka;
  wire [WEXP-1:0] dexp = kbig[WFULL-2 -: WEXP] - ksm[WFULL-2 -: WEXP];
  wire [W-1:0] big_ext = {(kbig[WFULL-2 -: WEXP] != '0), kbig[WF-1:0], 3'b000};
  wire [W-1:0] sm_ext  = {(ksm[WFULL-2 -: WEXP] != '0), ksm[WF-1:0], 3'b000};

  logic [2*W-1:0] shifted;
  logic [W-1:0]   sm_al;
  always_comb begin
    int shamt;
    shamt   = (int'(dexp) > W) ? W : int'(dexp);
    shifted = {sm_ext, {W{1'b0}}} >> shamt;
    sm_al   = {shifted[2*W-1:W+1], shifted[W] | (|shifted[W-1:0])};
  end

  logic             s1_v, s1_sub, s1_sign, s1_inf, s1_isg, s1_cancel;
  logic [W-1:0]     s1_big, s1_sm;
  logic [WEXP-1:0]  s1_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sub <= 1'b0; s1_sign <= 1'b0; s1_inf <= 1'b0;
      s1_isg <= 1'b0; s1_cancel <= 1'b0;
      s1_big <= '0; s1_sm <= '0; s1_e <= '0;
    end else begin
      s1_v      <= in_valid;
      s1_sub    <= sa ^ sb;
      s1_sign   <= a_big ? sa : sb;
      s1_inf    <= ia | ib;
      s1_isg    <= ia ? in_a[WFULL-1] : in_b[WFULL-1];
      s1_cancel <= ia & ib & (in_a[WFULL-1] != in_b[WFULL-1]);
      s1_big    <= big_ext;
      s1_sm     <= sm_al;
      s1_e      <= kbig[WFULL-2 -: WEXP];
    end
  end

  function automatic int lead_zeros(input logic [W-1:0] v);
    int n;
    n = W;
    for (int i = 0; i < W; i++) if (v[i]) n = W - 1 - i;
    return n;
  endfunction

  wire [W:0] sum = s1_sub ? ({1'b0, s1_big} - {1'b0, s1_sm})
                          : ({1'b0, s1_big} + {1'b0, s1_sm});

  logic [W-1:0]     norm;
  logic [WMAN:0]    mr;
  logic [WFULL-1:0] result;
  always_comb begin
    int lz, e1, e2;
    logic inc;
    lz = lead_zeros(sum[W-1:0]);
    if (sum[W]) begin
      norm = {sum[W:2], sum[1] | sum[0]};
      e1   = int'(s1_e) + 1;
    end else begin
      norm = sum[W-1:0] << lz;
      e1   = int'(s1_e) - lz;
    end
    inc = norm[2] & (norm[1] | norm[0] | norm[3]);
    mr  = {1'b0, norm[W-1:3]} + {{WMAN{1'b0}}, inc};
    e2  = e1 + int'(mr[WMAN]);
    if (s1_cancel)                  result = '0;
    else if (s1_inf)                result = {s1_isg, EONES, {WF{1'b0}}};
    else if (sum == '0 || e1 < 0)   result = '0;
    else if (e1 == 0)               result = {s1_sign, {{(WEXP-1){1'b0}}, 1'b1}, {WF{1'b0}}};
    else if (e2 >= EMAX)            result = {s1_sign, EONES, {WF{1'b0}}};
    else                            result = {s1_sign, e2[WEXP-1:0], mr[WF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= s1_v;
      out_sum   <= result;
    end
  end

  wire [WEXP-1:0] oe = out_sum[WFULL-2 -: WEXP];

  AST_VALID_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ##1 out_valid); // R1
  AST_IDLE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ##1 !out_valid); // R1
  AST_ZERO_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && oe == '0) |-> out_sum == '0); // R2
  AST_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zb && !za && !ia) |=> ##1 (out_sum == $past(in_a, 2))); // R2
  AST_INF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ia && !ib) |=> ##1 (oe == EONES && out_sum[WFULL-1] == $past(in_a[WFULL-1], 2))); // R4
  AST_INF_CLEAN_FRAC: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && oe == EONES) |-> out_sum[WF-1:0] == '0); // R8
endmodule

// File: tb/tb_cfloat_add.sv
module tb_cfloat_add;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_a, in_b;
  logic        out_valid, out_valid2;
  logic [31:0] out_sum, out_sum2;
  int          total = 0, fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  cfloat_add dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
                  .out_valid(out_valid), .out_sum(out_sum));
  cfloat_add #(.LATENCY(2)) dut_pinned (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a),
                  .in_b(in_b), .out_valid(out_valid2), .out_sum(out_sum2));

  localparam int NV = 29;
  // {a, b, expected, requirement number}
  localparam logic [103:0] VEC [NV] = '{
    {32'h3F800000, 32'h3F800000, 32'h40000000, 8'd3},  // R3 1+1
    {32'h40400000, 32'hBF800000, 32'h40000000, 8'd3},  // R3 3-1
    {32'h3F800000, 32'h40000000, 32'h40400000, 8'd3},  // R3 b larger
    {32'h3F800000, 32'hC0000000, 32'hBF800000, 8'd3},  // R3 sign of larger
    {32'h3F800000, 32'h33800000, 32'h3F800000, 8'd3},  // R3 tie, stays even
    {32'h3F800001, 32'h33800000, 32'h3F800002, 8'd3},  // R3 tie, up to even
    {32'h3F800000, 32'hB3000000, 32'h3F800000, 8'd3},  // R3 subtract tie back to 1.0
    {32'h3F800000, 32'h33800001, 32'h3F800001, 8'd10}, // R10 sticky breaks tie upward
    {32'h3F800000, 32'h33000000, 32'h3F800000, 8'd10}, // R10 below half
    {32'h3F800000, 32'hB3000001, 32'h3F7FFFFF, 8'd10}, // R10 sticky in subtraction
    {32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 8'd10}, // R10 huge exponent gap
    {32'h80000000, 32'h3F800000, 32'h3F800000, 8'd2},  // R2 negative zero
    {32'h00123456, 32'hC0000000, 32'hC0000000, 8'd2},  // R2 zero with fraction
    {32'h80000000, 32'h80000000, 32'h00000000, 8'd2},  // R2 zero sum canonical
    {32'h00800000, 32'h80000001, 32'h00800000, 8'd2},  // R2 min normal + dirty zero
    {32'h3F800000, 32'hBF800000, 32'h00000000, 8'd7},  // R7
    {32'hC1200000, 32'h41200000, 32'h00000000, 8'd7},  // R7
    {32'h7F800000, 32'hFF800000, 32'h00000000, 8'd4},  // R4 inf cancel
    {32'h7F800000, 32'hBF800000, 32'h7F800000, 8'd4},  // R4 inf + finite
    {32'hFF800000, 32'hFF800000, 32'hFF800000, 8'd4},  // R4 same-sign inf
    {32'hFFC00001, 32'h42000000, 32'hFF800000, 8'd8},  // R8 dirty inf
    {32'h7F812345, 32'hFF800000, 32'h00000000, 8'd8},  // R8 dirty inf cancel
    {32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 8'd5},  // R5
    {32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 8'd5},  // R5 negative
    {32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 8'd5},  // R5 rounding carry
    {32'h00E00000, 32'h80C00000, 32'h00000000, 8'd6},  // R6 quarter min
    {32'h00C00000, 32'h80800000, 32'h00800000, 8'd6},  // R6 half min
    {32'h80C00000, 32'h00800000, 32'h80800000, 8'd6},  // R6 negative half min
    {32'h00800000, 32'h00800000, 32'h01000000, 8'd6}   // R6 boundary normal
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset sum", out_sum, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk($sformatf("R1 valid vec %0d", i - 2), {31'd0, out_valid}, 32'd1);
        chk($sformatf("R%0d vec %0d", VEC[i-2][7:0], i - 2), out_sum, VEC[i-2][39:8]);
      end
      if (i < NV) begin
        in_valid = 1'b1; in_a = VEC[i][103:72]; in_b = VEC[i][71:40];
      end else begin
        in_valid = 1'b0;
      end
    end
    // R1 single pulse timing, R9 pinned latency copy tracks the default one
    @(negedge clk);
    in_valid = 1'b1; in_a = 32'h40000000; in_b = 32'h40000000;
    @(negedge clk);
    in_valid = 1'b0; in_a = '0; in_b = '0;
    chk("R1 not after one cycle", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R1 valid after two", {31'd0, out_valid}, 32'd1);
    chk("R1 pulse sum", out_sum, 32'h40800000);
    chk("R9 pinned valid", {31'd0, out_valid2}, 32'd1);
    chk("R9 pinned sum", out_sum2, 32'h40800000);
    @(negedge clk);
    chk("R1 drops after pulse", {31'd0, out_valid}, 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule